// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Logic Target

This block loads a configuration bitstream into a downstream programmable-logic device over a bit-serial slave link. A host issues a one-cycle `start` pulse together with a byte count, a pulse length and a mode selection. The image bytes then arrive on a ready/valid byte stream, and the loader turns them into a serial clock and data waveform on the target pins.

The sequence has four stages. First the loader holds the target's active-low clear line low for the requested number of cycles. It then waits, with a time limit, for the target to release its active-low wait line. Next it shifts every byte out most significant bit first. Finally it keeps clocking the target until the target signals that it is up, again with a time limit.

An optional word-swap mode serves images stored as little-endian 32-bit words. In this mode the four bytes of every word are sent in reverse order, so stream byte `i` is sent in position `i XOR 3`. Any failure ends the load with a sticky error flag. A clean finish sets a sticky done flag.

The controller has the following states and transitions:
- `ST_IDLE`: waits for `start`. A valid request goes to `ST_PULSE`. A rejected request stays in `ST_IDLE` and raises the error flag.
- `ST_PULSE`: holds the clear line low, then goes to `ST_WAIT_INIT`.
- `ST_WAIT_INIT`: goes to `ST_FETCH` when the wait line releases, or straight to `ST_FLUSH` if the count is zero. It returns to `ST_IDLE` with an error when the time limit expires.
- `ST_FETCH`: takes the next byte and goes to `ST_SHIFT`.
- `ST_SHIFT`: sends eight bits. After the last bit of a byte it goes to `ST_FETCH`, or to `ST_FLUSH` if the image is finished.
- `ST_FLUSH`: goes to `ST_IDLE` with done when the target is up, or to `ST_IDLE` with error when the pulse limit expires.

Top module: `cfg_loader`

## Requirements
- R1: After reset the outputs are at rest: `tgt_rst_n` high, `tgt_sclk` low, `tgt_sdo` low, `tgt_pwr` low, and `busy`, `load_ok`, `load_err` and `s_ready` all low.
- R2: An accepted `start` raises `tgt_pwr`, which stays high. `tgt_rst_n` then goes low for exactly max(`pulse_len`,1) clock cycles, and this happens once per load.
- R3: After `tgt_rst_n` returns high, the loader waits for `tgt_wait_n` to be high. If `tgt_wait_n` stays low for INIT_TIMEOUT cycles, the load ends with `load_err` and no `tgt_sclk` pulse at all. `tgt_sclk` is never high while `tgt_rst_n` is low.
- R4: Bytes are sent most significant bit first. The bit is placed on `tgt_sdo` before `tgt_sclk` rises and held for the whole high phase. Each data high phase lasts exactly HALF_CYC cycles, and each low phase lasts at least HALF_CYC cycles.
- R5: Exactly `byte_count` bytes are taken from the stream. `s_ready` is low whenever `busy` is low.
- R6: After the last byte, `tgt_sclk` keeps pulsing until `tgt_up` is high. No pulse is added if `tgt_up` is already high. If `tgt_up` is still low after DONE_TIMEOUT extra pulses, the load ends with `load_err`.
- R7: With `rev_mode` high, the n-th byte sent is stream byte n XOR 3. The order is 3,2,1,0,7,6,5,4 and so on.
- R8: A request with `rev_mode` high is rejected when `img_aligned` is low or when `byte_count` is not a multiple of 4. A rejected request sets `load_err` and `busy` never rises. `tgt_rst_n` never goes low and no stream byte is taken.
- R9: `load_ok` and `load_err` are never both high, and both are low while `busy` is high. Each flag holds its value until the next `start`.
- R10: A `start` pulse while `busy` is high is ignored. The running load completes unchanged and no second clear pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| rev_mode | input | 1 | Send the bytes of each 4-byte word in reverse order |
| img_aligned | input | 1 | Image start is 4-byte aligned |
| byte_count | input | CNT_W | Number of image bytes |
| pulse_len | input | PULSE_W | Clear-pulse length in clock cycles |
| s_data | input | BYTE_W | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Loader accepts a stream byte |
| tgt_wait_n | input | 1 | Target ready for data (low while the target clears) |
| tgt_up | input | 1 | Target reports configuration complete |
| tgt_rst_n | output | 1 | Active-low target clear |
| tgt_sclk | output | 1 | Serial configuration clock |
| tgt_sdo | output | 1 | Serial configuration data |
| tgt_pwr | output | 1 | Target power enable |
| busy | output | 1 | Load in progress |
| load_ok | output | 1 | Last load finished cleanly (sticky) |
| load_err | output | 1 | Last load failed or was rejected (sticky) |

## Verification
A corrupted shift register or bit counter shows up within one byte time as a wrong byte in the target model's received image. A wrong byte counter or word-buffer index shows up as a wrong byte count, or as a byte-order mismatch that appears at the first 4-byte word. A faulty timeout counter shows up at the end of the load as a wrong number of extra clock pulses or as a missing error flag. A faulty state decode shows up as a clear pulse of the wrong length, or as clock activity while the clear line is low, in the same cycle as the fault.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_SHIFT,
        ST_FLUSH
    } ld_state_t;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/cfg_phase_gen.sv
module cfg_phase_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic phase_hi,
    output logic bit_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;
    logic          hi;
    logic          last;

    assign last     = (cnt == CW'(HALF_CYC - 1));
    assign phase_hi = hi;
    assign bit_end  = run && hi && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            hi  <= 1'b0;
        end else if (last) begin
            cnt <= '0;
            hi  <= ~hi;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/cfg_byte_feed.sv
module cfg_byte_feed #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              en,
    input  logic              swap,
    input  logic [CNT_W-1:0]  total,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_valid,
    output logic              s_ready,
    output logic              f_valid,
    output logic [BYTE_W-1:0] f_byte,
    input  logic              take
);
    import cfg_loader_pkg::*;

    localparam int IW = $clog2(WORD_BYTES);
    localparam int FW = IW + 1;

    logic [BYTE_W-1:0] wbuf [WORD_BYTES];
    logic [FW-1:0]     fill;
    logic [IW-1:0]     idx;
    logic              drain;
    logic              swap_q;
    logic [CNT_W-1:0]  acc_left;
    logic [FW-1:0]     group;
    logic              accept;

    assign group   = swap_q ? FW'(WORD_BYTES) : FW'(1);
    assign s_ready = en && !drain && (acc_left != '0);
    assign accept  = s_ready && s_valid;
    assign f_valid = drain;
    assign f_byte  = wbuf[idx];

    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                wbuf[g] <= '0;
            else if (accept && (fill[IW-1:0] == IW'(g)))
                wbuf[g] <= s_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill     <= '0;
            idx      <= '0;
            drain    <= 1'b0;
            swap_q   <= 1'b0;
            acc_left <= '0;
        end else if (load) begin
            fill     <= '0;
            idx      <= '0;
            drain    <= 1'b0;
            swap_q   <= swap;
            acc_left <= total;
        end else begin
            if (accept) begin
                acc_left <= acc_left - CNT_W'(1);
                if (fill + FW'(1) == group) begin
                    drain <= 1'b1;
                    idx   <= IW'(group - FW'(1));
                    fill  <= '0;
                end else begin
                    fill <= fill + FW'(1);
                end
            end
            if (drain && take) begin
                if (idx == '0)
                    drain <= 1'b0;
                else
                    idx <= idx - IW'(1);
            end
        end
    end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
    parameter int BYTE_W       = 8,
    parameter int CNT_W        = 16,
    parameter int PULSE_W      = 16,
    parameter int HALF_CYC     = 2,
    parameter int INIT_TIMEOUT = 100000,
    parameter int DONE_TIMEOUT = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rev_mode,
    input  logic               img_aligned,
    input  logic [CNT_W-1:0]   byte_count,
    input  logic [PULSE_W-1:0] pulse_len,
    input  logic [BYTE_W-1:0]  s_data,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic               tgt_wait_n,
    input  logic               tgt_up,
    output logic               tgt_rst_n,
    output logic               tgt_sclk,
    output logic               tgt_sdo,
    output logic               tgt_pwr,
    output logic               busy,
    output logic               load_ok,
    output logic               load_err
);
    import cfg_loader_pkg::*;

    localparam int TW_I   = $clog2(INIT_TIMEOUT + 1);
    localparam int TW_D   = $clog2(DONE_TIMEOUT + 1);
    localparam int TW_ID  = (TW_I > TW_D) ? TW_I : TW_D;
    localparam int TMO_W  = ((TW_ID > PULSE_W) ? TW_ID : PULSE_W) + 1;
    localparam int BIT_CW = $clog2(BYTE_W + 1);

    ld_state_t          st, nxt;
    logic [TMO_W-1:0]   tmo;
    logic [PULSE_W-1:0] pulse_q;
    logic [CNT_W-1:0]   bytes_left;
    logic [BYTE_W-1:0]  sreg;
    logic [BIT_CW-1:0]  bits_left;
    logic               bad_req;
    logic               accept_req;
    logic               fin_ok, fin_err;
    logic               take;
    logic               run, phase_hi, bit_end;
    logic               f_valid;
    logic [BYTE_W-1:0]  f_byte;

    assign bad_req    = rev_mode && (!img_aligned || (byte_count[1:0] != 2'b00));
    assign accept_req = (st == ST_IDLE) && start && !bad_req;
    assign run        = (st == ST_SHIFT) || (st == ST_FLUSH);

    cfg_phase_gen #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .phase_hi (phase_hi),
        .bit_end  (bit_end)
    );

    cfg_byte_feed #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept_req),
        .en      (busy),
        .swap    (rev_mode),
        .total   (byte_count),
        .s_data  (s_data),
        .s_valid (s_valid),
        .s_ready (s_ready),
        .f_valid (f_valid),
        .f_byte  (f_byte),
        .take    (take)
    );

    // next-state decode
    always_comb begin
        nxt     = st;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        take    = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    if (bad_req) fin_err = 1'b1;
                    else         nxt = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if ((tmo + TMO_W'(1)) >= TMO_W'(pulse_q))
                    nxt = ST_WAIT_INIT;
            end
            ST_WAIT_INIT: begin
                if (tgt_wait_n) begin
                    nxt = (bytes_left == '0) ? ST_FLUSH : ST_FETCH;
                end else if (tmo == TMO_W'(INIT_TIMEOUT - 1)) begin
                    nxt     = ST_IDLE;
                    fin_err = 1'b1;
                end
            end
            ST_FETCH: begin
                if (f_valid) begin
                    take = 1'b1;
                    nxt  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (bit_end && (bits_left == BIT_CW'(1)))
                    nxt = (bytes_left == '0) ? ST_FLUSH : ST_FETCH;
            end
            ST_FLUSH: begin
                if (tgt_up) begin
                    nxt    = ST_IDLE;
                    fin_ok = 1'b1;
                end else if (bit_end && (tmo == TMO_W'(DONE_TIMEOUT - 1))) begin
                    nxt     = ST_IDLE;
                    fin_err = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // datapath: counters and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo        <= '0;
            pulse_q    <= '0;
            bytes_left <= '0;
            sreg       <= '0;
            bits_left  <= '0;
        end else begin
            if (accept_req) begin
                pulse_q    <= pulse_len;
                bytes_left <= byte_count;
            end
            if (nxt != st)
                tmo <= '0;
            else if ((st == ST_PULSE) || (st == ST_WAIT_INIT) || ((st == ST_FLUSH) && bit_end))
                tmo <= tmo + TMO_W'(1);
            if (take) begin
                sreg       <= f_byte;
                bits_left  <= BIT_CW'(BYTE_W);
                bytes_left <= bytes_left - CNT_W'(1);
            end else if ((st == ST_SHIFT) && bit_end) begin
                sreg      <= {sreg[BYTE_W-2:0], 1'b0};
                bits_left <= bits_left - BIT_CW'(1);
            end
        end
    end

    // outputs: sticky flags and power enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_ok  <= 1'b0;
            load_err <= 1'b0;
            tgt_pwr  <= 1'b0;
        end else begin
            if ((st == ST_IDLE) && start) begin
                load_ok  <= 1'b0;
                load_err <= fin_err;
                if (!bad_req) tgt_pwr <= 1'b1;
            end else begin
                if (fin_ok)  load_ok  <= 1'b1;
                if (fin_err) load_err <= 1'b1;
            end
        end
    end

    assign busy      = (st != ST_IDLE);
    assign tgt_rst_n = (st != ST_PULSE);
    assign tgt_sclk  = run && phase_hi;
    assign tgt_sdo   = (st == ST_SHIFT) ? sreg[BYTE_W-1] : 1'b0;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic s_ready,
    input logic tgt_rst_n,
    input logic tgt_sclk,
    input logic tgt_sdo,
    input logic busy,
    input logic load_ok,
    input logic load_err
);
    AST_SCLK_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sclk |-> tgt_rst_n);  // R3

    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sclk && $past(tgt_sclk)) |-> $stable(tgt_sdo));  // R4

    AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !s_ready);  // R5

    AST_CLEAR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n |-> busy);  // R2

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok && load_err));  // R9

    AST_FLAGS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!load_ok && !load_err));  // R9

    AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ok && !start) |=> load_ok);  // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (load_err && !start) |=> load_err);  // R9
endmodule

bind cfg_loader cfg_loader_chk u_chk (.*);

// File: tb/cfg_loader_test.sv
`timescale 1ns/1ps
module cfg_loader_test;
    localparam int HALF = 2;
    localparam int ITO  = 50;
    localparam int DTO  = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, rev_mode = 1'b0, img_aligned = 1'b1;
    logic [15:0] byte_count = '0, pulse_len = '0;
    logic [7:0]  s_data = '0;
    logic        s_valid = 1'b0, s_ready;
    logic        tgt_wait_n = 1'b1, tgt_up = 1'b0;
    logic        tgt_rst_n, tgt_sclk, tgt_sdo, tgt_pwr, busy, load_ok, load_err;

    cfg_loader #(.HALF_CYC(HALF), .INIT_TIMEOUT(ITO), .DONE_TIMEOUT(DTO)) uut (.*);

    always #2.5 clk = ~clk;

    int errors = 0, checks = 0;
    logic [7:0] src [64];
    logic [7:0] rx  [64];
    int src_len = 0, idx = 0;
    bit pend = 0, feed_on = 0;
    int need = 0, init_hold = 0, extra_need = 0;
    int rx_cnt = 0, bitn = 0, extra_rises = 0, hold_cnt = 0;
    int prog_lows = 0, prog_falls = 0, hi_run = 0, hi_bad = 0;
    bit sclk_q = 0, prog_q = 1, run_data = 0;
    logic [7:0] shreg = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int i, input bit rev);
        return src[rev ? (i ^ 3) : i];
    endfunction

    // stream source
    always @(negedge clk) begin
        if (pend) idx++;
        if (!(s_valid && !pend)) s_valid = feed_on && (idx < src_len) && ($urandom % 3 != 0);
        s_data = src[idx % 64];
        pend = s_valid && s_ready;
    end

    // target model
    always @(negedge clk) begin
        if (!tgt_rst_n) begin
            tgt_wait_n = 1'b0; hold_cnt = 0; rx_cnt = 0; bitn = 0; extra_rises = 0;
        end else begin
            if (hold_cnt >= init_hold) tgt_wait_n = 1'b1; else hold_cnt++;
        end
        if (tgt_rst_n && prog_q == 1'b0) prog_falls += 0;
        if (!tgt_rst_n) prog_lows++;
        if (!tgt_rst_n && prog_q) prog_falls++;
        prog_q = tgt_rst_n;
        if (tgt_sclk && !sclk_q) begin
            if (rx_cnt < need) begin
                shreg = {shreg[6:0], tgt_sdo};
                bitn++;
                run_data = 1;
                if (bitn == 8) begin rx[rx_cnt % 64] = shreg; rx_cnt++; bitn = 0; end
            end else begin
                extra_rises++;
                run_data = 0;
            end
        end
        if (tgt_sclk) hi_run++;
        else begin
            if (sclk_q && run_data && hi_run != HALF) hi_bad++;
            hi_run = 0;
        end
        sclk_q = tgt_sclk;
        tgt_up = (rx_cnt == need) && (extra_rises >= extra_need) && tgt_rst_n && need >= 0 && tgt_wait_n;
    end

    task automatic run_load(input int n, input bit rev, input bit aligned, input int plen,
                            input int ihold, input int xneed, input bit poke);
        for (int i = 0; i < 64; i++) src[i] = 8'($urandom);
        @(negedge clk);
        src_len = n; idx = 0; need = n; init_hold = ihold; extra_need = xneed;
        prog_lows = 0; prog_falls = 0; hi_bad = 0; extra_rises = 0; rx_cnt = 0;
        feed_on = 1;
        rev_mode = rev; img_aligned = aligned; byte_count = 16'(n); pulse_len = 16'(plen);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20000 && busy; c++) begin
            @(negedge clk);
            if (poke && c == 40) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        feed_on = 0;
    endtask

    task automatic check_image(input int n, input bit rev, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) if (rx[i] !== exp_byte(i, rev)) bad++;
        chk(bad == 0, req, bad, 0);
        chk(rx_cnt == n && idx == n, "R5", rx_cnt, n);
    endtask

    initial begin : watchdog
        #900000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tgt_rst_n && !tgt_sclk && !tgt_sdo && !tgt_pwr && !busy && !load_ok && !load_err && !s_ready,
            "R1", 0, 1);

        // normal load, directed
        run_load(9, 0, 1, 5, 3, 4, 0);
        chk(prog_lows == 5 && prog_falls == 1, "R2", prog_lows, 5);
        chk(tgt_pwr == 1'b1, "R2", tgt_pwr, 1);
        check_image(9, 0, "R4");
        chk(hi_bad == 0, "R4", hi_bad, 0);
        chk(extra_rises == 4, "R6", extra_rises, 4);
        chk(load_ok && !load_err && !busy, "R9", {load_ok, load_err}, 2);

        // pulse length zero counts as one
        run_load(3, 0, 1, 0, 0, 0, 0);
        chk(prog_lows == 1, "R2", prog_lows, 1);
        chk(extra_rises == 0 && load_ok, "R6", extra_rises, 0);
        check_image(3, 0, "R4");

        // random normal and swapped loads
        for (int k = 0; k < 6; k++) begin
            int n = 4 * (1 + int'($urandom % 8));
            bit rv = k[0];
            int xn = int'($urandom % 6);
            run_load(n, rv, 1, 1 + int'($urandom % 7), int'($urandom % 10), xn, 0);
            check_image(n, rv, rv ? "R7" : "R4");
            chk(extra_rises == xn && load_ok, "R6", extra_rises, xn);
        end

        // swapped mode rejections
        run_load(8, 1, 0, 4, 0, 0, 0);
        chk(load_err && !load_ok && prog_falls == 0 && idx == 0, "R8", prog_falls, 0);
        run_load(6, 1, 1, 4, 0, 0, 0);
        chk(load_err && prog_falls == 0 && idx == 0, "R8", idx, 0);
        chk(!busy, "R8", busy, 0);

        // wait-line timeout
        run_load(4, 0, 1, 3, 1000, 0, 0);
        chk(load_err && !load_ok, "R3", load_err, 1);
        chk(rx_cnt == 0 && extra_rises == 0, "R3", rx_cnt, 0);

        // up-line timeout
        run_load(4, 0, 1, 3, 0, 1000, 0);
        chk(load_err && !load_ok, "R6", load_err, 1);
        chk(extra_rises == DTO, "R6", extra_rises, DTO);

        // error flag sticky across idle cycles
        repeat (10) @(negedge clk);
        chk(load_err && !load_ok, "R9", load_err, 1);

        // start while busy ignored
        run_load(12, 0, 1, 6, 2, 2, 1);
        chk(prog_falls == 1, "R10", prog_falls, 1);
        check_image(12, 0, "R10");
        chk(load_ok && !load_err, "R10", load_ok, 1);

        // zero-byte image
        run_load(0, 0, 1, 2, 1, 3, 0);
        chk(load_ok && extra_rises == 3, "R6", extra_rises, 3);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule